// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block produces the serial clock waveform for an I2C bus master from a fast system clock. A programmable prescaler divides the system clock into a slower module rate. The module rate is delivered as a one-cycle enable pulse, so the whole design stays in one clock domain. Two phase counters, one for the low half and one for the high half, then count module periods to set the SCL period and duty cycle. Each phase is stretched by a fixed extra number of module periods. That offset is 7 when the prescale setting is 0, 6 when it is 1, and 5 when it is 2 or more.

The master engine raises `run` to request bus activity. While `run` is low, SCL rests high. A module enable input acts as the block's reset. While it is low, the divider is cleared, SCL is released high, and the three 16-bit settings are captured. While it is high, the captured settings are frozen. Two strobes mark the middle of each low phase and each high phase. A data shifter can use them to change SDA or to sample it. The prescale value should be chosen so that the module rate lands roughly between 7 and 12 MHz.

Top module: `scl_clock_gen`

## Requirements
- R1: The module tick occurs once every (P+1) system clock cycles, where P is the captured prescale value, so every phase width is a whole multiple of (P+1).
- R2: Each SCL low phase lasts (L + d) × (P+1) system clock cycles, where L is the captured low count.
- R3: Each SCL high phase between two low phases lasts (H + d) × (P+1) system clock cycles, where H is the captured high count.
- R4: The phase offset d is 7 for P = 0, 6 for P = 1 and 5 for any P of 2 or more.
- R5: On the cycle after `mod_en` is sampled low, `scl_out` is 1 and both strobes are 0, and they stay that way while `mod_en` stays low.
- R6: `psc_val`, `low_cnt` and `high_cnt` are captured only while `mod_en` is low. Changing them while `mod_en` is high has no effect on the waveform.
- R7: With `run` high, the first low phase starts on the first module tick after `mod_en` rises, so `scl_out` falls (P+2) cycles after the first clock edge that samples `mod_en` high. With `run` low at the end of a high phase, SCL stays high and no further phase starts.
- R8: `mid_low` pulses for exactly one cycle per low phase, while `scl_out` is 0, at (floor((L+d)/2) + 1) × (P+1) cycles after the falling edge of `scl_out`.
- R9: `mid_high` pulses for exactly one cycle per high phase, while `scl_out` is 1, at (floor((H+d)/2) + 1) × (P+1) cycles after the rising edge of `scl_out`.
- R10: After synchronous reset `rst`, `scl_out` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable; low holds the divider cleared and captures settings |
| psc_val | input | 16 | Prescale setting P |
| low_cnt | input | 16 | Low phase count L |
| high_cnt | input | 16 | High phase count H |
| run | input | 1 | Request for bus clocking from the master engine |
| scl_out | output | 1 | SCL drive level (1 = released high) |
| mid_low | output | 1 | One-cycle strobe at the middle of the low phase |
| mid_high | output | 1 | One-cycle strobe at the middle of the high phase |

## Verification
Two events can land on the same clock edge. The master can drop `run` on the tick that ends a high phase, and `mod_en` can fall during a phase that is due to produce a mid strobe. The bench withdraws `run` just as a high phase begins. It then confirms that this phase completes with its single `mid_high` and that SCL stays high afterwards. It also drops `mod_en` in the middle of a low phase and requires SCL high, with no strobe, from the next cycle on. Phase widths and strobe offsets are measured in system cycles and compared with the formulas for prescale values 0, 1 and 3, and for random settings.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int CFG_W = 16;
    localparam int LEN_W = CFG_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CFG_W-1:0] psc;
        logic [CFG_W-1:0] lo;
        logic [CFG_W-1:0] hi;
    } div_cfg_t;

    // Extra module periods added to every phase.
    function automatic logic [2:0] phase_offset(input logic [CFG_W-1:0] p);
        if (p == '0)
            return 3'd7;
        else if (p == CFG_W'(1))
            return 3'd6;
        else
            return 3'd5;
    endfunction

endpackage

// File: rtl/scl_cfg_capture.sv
module scl_cfg_capture
    import scl_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  div_cfg_t cfg_in,
    output div_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (!en)
            cfg_q <= cfg_in;
    end

    // R6: settings are frozen while the module is enabled
    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst)) |-> $stable(cfg_q));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CFG_W-1:0] psc,
    output logic             tick
);

    logic [CFG_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == psc) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R1: with a nonzero prescale, ticks are never back to back
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst || !en)
        (tick && psc != '0) |=> !tick);

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             run,
    input  logic [LEN_W-1:0] len_low,
    input  logic [LEN_W-1:0] len_high,
    output logic             scl,
    output logic             mid_lo,
    output logic             mid_hi
);

    phase_e           state_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] half_low;
    logic [LEN_W-1:0] half_high;

    assign half_low  = len_low  >> 1;
    assign half_high = len_high >> 1;
    assign scl       = (state_q != PH_LOW);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            mid_lo  <= 1'b0;
            mid_hi  <= 1'b0;
        end else begin
            mid_lo <= 1'b0;
            mid_hi <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    PH_IDLE: begin
                        if (run) begin
                            state_q <= PH_LOW;
                            cnt_q   <= '0;
                        end
                    end
                    PH_LOW: begin
                        mid_lo <= (cnt_q == half_low);
                        if (cnt_q == len_low - 1'b1) begin
                            state_q <= PH_HIGH;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        mid_hi <= (cnt_q == half_high);
                        if (cnt_q == len_high - 1'b1) begin
                            state_q <= run ? PH_LOW : PH_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= PH_IDLE;
                endcase
            end
        end
    end

    // R8: the low strobe appears only while SCL is driven low
    assert_mid_low_in_phase_R8: assert property (@(posedge clk) disable iff (rst)
        mid_lo |-> !scl);

    // R9: the high strobe appears only while SCL is released
    assert_mid_high_in_phase_R9: assert property (@(posedge clk) disable iff (rst)
        mid_hi |-> scl);

    // R2: the low-phase counter never passes its phase length
    assert_low_count_bound_R2: assert property (@(posedge clk) disable iff (rst || !en)
        (state_q == PH_LOW) |-> (cnt_q < len_low));

    // R3: the high-phase counter never passes its phase length
    assert_high_count_bound_R3: assert property (@(posedge clk) disable iff (rst || !en)
        (state_q == PH_HIGH) |-> (cnt_q < len_high));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_div_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mod_en,
    input  logic [15:0] psc_val,
    input  logic [15:0] low_cnt,
    input  logic [15:0] high_cnt,
    input  logic        run,
    output logic        scl_out,
    output logic        mid_low,
    output logic        mid_high
);

    div_cfg_t         cfg_in;
    div_cfg_t         cfg_q;
    logic             tick;
    logic [2:0]       offs;
    logic [LEN_W-1:0] len_low;
    logic [LEN_W-1:0] len_high;

    assign cfg_in   = '{psc: psc_val, lo: low_cnt, hi: high_cnt};
    assign offs     = phase_offset(cfg_q.psc);
    assign len_low  = LEN_W'(cfg_q.lo) + LEN_W'(offs);
    assign len_high = LEN_W'(cfg_q.hi) + LEN_W'(offs);

    scl_cfg_capture u_cfg (
        .clk    (clk),
        .rst    (rst),
        .en     (mod_en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    scl_prescaler u_psc (
        .clk  (clk),
        .rst  (rst),
        .en   (mod_en),
        .psc  (cfg_q.psc),
        .tick (tick)
    );

    scl_phase_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (mod_en),
        .tick     (tick),
        .run      (run),
        .len_low  (len_low),
        .len_high (len_high),
        .scl      (scl_out),
        .mid_lo   (mid_low),
        .mid_hi   (mid_high)
    );

    // R5: a disabled module releases SCL and stays quiet
    assert_disable_release_R5: assert property (@(posedge clk) disable iff (rst)
        !mod_en |=> (scl_out && !mid_low && !mid_high));

    // R8 and R9: the two strobes never coincide
    assert_mid_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(mid_low && mid_high));

endmodule

// File: tb/tb_scl_clock_gen.sv
`timescale 1ns/1ps
module tb_scl_clock_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        mod_en;
    logic [15:0] psc_val;
    logic [15:0] low_cnt;
    logic [15:0] high_cnt;
    logic        run;
    logic        scl_out;
    logic        mid_low;
    logic        mid_high;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    scl_clock_gen dut (
        .clk      (clk),
        .rst      (rst),
        .mod_en   (mod_en),
        .psc_val  (psc_val),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt),
        .run      (run),
        .scl_out  (scl_out),
        .mid_low  (mid_low),
        .mid_high (mid_high)
    );

    function automatic int exp_d(input int p);
        if (p == 0) return 7;
        if (p == 1) return 6;
        return 5;
    endfunction

    function automatic int exp_width(input int c, input int p);
        return (c + exp_d(p)) * (p + 1);
    endfunction

    function automatic int exp_mid(input int c, input int p);
        return (((c + exp_d(p)) / 2) + 1) * (p + 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge right after scl changed to lvl; returns phase width,
    // strobe offset and strobe count for the phase at level lvl.
    task automatic measure_phase(input logic lvl, output int width,
                                 output int midpos, output int nmid);
        int n = 0;
        midpos = -1;
        nmid = 0;
        forever begin
            @(negedge clk);
            n++;
            if ((lvl == 1'b0 && mid_low) || (lvl == 1'b1 && mid_high)) begin
                nmid++;
                midpos = n;
            end
            if (scl_out != lvl) break;
            if (n > 2000) break;
        end
        width = n;
    endtask

    task automatic start_cfg(input int p, input int lo, input int hi, output int lat);
        int n = 0;
        @(negedge clk);
        mod_en   = 1'b0;
        psc_val  = 16'(p);
        low_cnt  = 16'(lo);
        high_cnt = 16'(hi);
        run      = 1'b1;
        repeat (3) @(negedge clk);
        mod_en = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (!scl_out || n > 2000) break;
        end
        lat = n;
    endtask

    task automatic run_cfg(input int p, input int lo, input int hi, input int periods);
        int lat, w, m, k;
        start_cfg(p, lo, hi, lat);
        check("R7 start latency", lat, p + 2);
        for (int i = 0; i < periods; i++) begin
            measure_phase(1'b0, w, m, k);
            check("R2 low width", w, exp_width(lo, p));
            check("R8 mid_low offset", m, exp_mid(lo, p));
            check("R8 mid_low count", k, 1);
            measure_phase(1'b1, w, m, k);
            check("R3 high width", w, exp_width(hi, p));
            check("R9 mid_high offset", m, exp_mid(hi, p));
            check("R9 mid_high count", k, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w, m, k, lat, bad;
        void'($urandom(32'd1234));
        rst = 1'b1; mod_en = 1'b0; run = 1'b0;
        psc_val = '0; low_cnt = '0; high_cnt = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset scl", int'(scl_out), 1);
        check("R10 reset strobes", int'(mid_low) + int'(mid_high), 0);

        // R4 / R1: offset and prescale for P = 0, 1, 3
        run_cfg(0, 3, 4, 2);
        run_cfg(1, 2, 6, 2);
        run_cfg(3, 1, 0, 2);

        // R6: change settings while enabled, waveform keeps captured values
        start_cfg(1, 4, 3, lat);
        low_cnt = 16'd20; high_cnt = 16'd1; psc_val = 16'd5;
        measure_phase(1'b0, w, m, k);
        check("R6 low width after change", w, exp_width(4, 1));
        measure_phase(1'b1, w, m, k);
        check("R6 high width after change", w, exp_width(3, 1));

        // R7: drop run as a high phase begins; phase completes, then idle
        measure_phase(1'b0, w, m, k);
        run = 1'b0;
        measure_phase(1'b1, w, m, k);
        check("R7 final high strobe count", k, 1);
        check("R7 stays high after run drop", int'(scl_out == 1'b1 && w > 200), 1);

        // R5: disable mid-low phase
        start_cfg(2, 6, 6, lat);
        repeat (5) @(negedge clk);
        mod_en = 1'b0;
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (!scl_out || mid_low || mid_high) bad++;
        end
        check("R5 disabled released", bad, 0);

        // random mix
        for (int i = 0; i < 6; i++) begin
            int p = int'($urandom_range(4, 0));
            int lo = int'($urandom_range(12, 0));
            int hi = int'($urandom_range(12, 0));
            run_cfg(p, lo, hi, 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule